// File: doc/BRIEF.md
# Fused-Port Wide Vector Dispatcher

This block sits behind the scheduler of a vector-capable core. It sees up to three micro-ops per cycle, one offered on each of three execution ports (0, 1 and 5). It steers each op onto one of five execution resources: two 256-bit vector lanes (one on port 0, one on port 1), two single-cycle scalar integer ALUs (one on port 0, one on port 1) and, when the build includes it, a dedicated 512-bit vector unit on port 5. A 512-bit op offered on port 0 is run as a fused operation that takes over the port 1 vector lane as well. The port 1 scalar ALU stays free, so integer work on port 1 can still issue in that cycle.

The handshake on each port has a valid and a ready. The ready is combinational and depends only on the kinds of op offered this cycle. An op issues when valid and ready are both high. A refused op stays with the scheduler, which offers it again. Every resource is a fixed-latency, fully pipelined shift of valid bits and destination tags. Vector work writes its tag back four cycles after it issues and scalar work one cycle after. The arithmetic itself is not modelled. An op that no port can legally carry is refused and raises a one-cycle illegal-dispatch flag.

Top module: `vdisp_top`

## Requirements
- R1: Op kind encoding on every port is 0 = scalar integer, 1 = 256-bit vector, 2 = 512-bit vector, 3 = reserved. A scalar op on port 0 or port 1 writes back on that port's ALU bus. A 256-bit op on port 0 or port 1 writes back on that port's vector-lane bus with wide flag 0.
- R2: A 512-bit op on port 0 always issues. It writes back on the port 0 lane bus with the wide flag set, and the port 1 lane bus shows no writeback in that cycle.
- R3: While a 512-bit op is offered valid on port 0, port 1 ready is low for a 256-bit op. That op does not issue, and it issues once it is offered again in a cycle without the conflict.
- R4: A scalar op on port 1 is ready and issues in the same cycle as a fused 512-bit op on port 0.
- R5: The tag of an issued vector op appears on its writeback bus exactly 4 cycles after the issue cycle. The tag of a scalar op appears exactly 1 cycle after.
- R6: Every resource accepts a new op every cycle. Back-to-back ops write back in consecutive cycles in issue order.
- R7: When HAS_P5 = 1, a 512-bit op on port 5 issues and writes back on the port 5 unit bus 4 cycles later. When HAS_P5 = 0, port 5 ready is always low and that bus never shows a writeback.
- R8: These offers are illegal: reserved kind on any port, a 512-bit op on port 1, any kind other than 512-bit on port 5, and a 512-bit op on port 5 without the unit. Such an offer has ready low. It raises illegal_o in the same cycle when offered valid, and it produces no writeback. A stall under R3 does not raise illegal_o.
- R9: Synchronous active-high reset clears every in-flight op. In the cycle after a reset cycle no writeback bus is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Op offered on port 0 |
| p0_kind | input | 2 | Port 0 op kind |
| p0_tag | input | TAG_W | Port 0 destination tag |
| p1_valid | input | 1 | Op offered on port 1 |
| p1_kind | input | 2 | Port 1 op kind |
| p1_tag | input | TAG_W | Port 1 destination tag |
| p5_valid | input | 1 | Op offered on port 5 |
| p5_kind | input | 2 | Port 5 op kind |
| p5_tag | input | TAG_W | Port 5 destination tag |
| p0_ready | output | 1 | Port 0 op would issue this cycle |
| p1_ready | output | 1 | Port 1 op would issue this cycle |
| p5_ready | output | 1 | Port 5 op would issue this cycle |
| illegal_o | output | 1 | A valid offer this cycle is illegal |
| wb_alu0_valid | output | 1 | Port 0 ALU writeback |
| wb_alu0_tag | output | TAG_W | Port 0 ALU writeback tag |
| wb_alu1_valid | output | 1 | Port 1 ALU writeback |
| wb_alu1_tag | output | TAG_W | Port 1 ALU writeback tag |
| wb_vl0_valid | output | 1 | Port 0 vector lane writeback |
| wb_vl0_tag | output | TAG_W | Port 0 vector lane writeback tag |
| wb_vl0_wide | output | 1 | Writeback belongs to a fused 512-bit op |
| wb_vl1_valid | output | 1 | Port 1 vector lane writeback |
| wb_vl1_tag | output | TAG_W | Port 1 vector lane writeback tag |
| wb_u5_valid | output | 1 | Port 5 512-bit unit writeback |
| wb_u5_tag | output | TAG_W | Port 5 unit writeback tag |

## Verification
If the lane-sharing decision goes wrong, the fault shows in the same cycle on p1_ready. Four cycles later it also shows as a port 1 lane writeback that either collides with a wide port 0 writeback or is missing. A stage lost or doubled in a latency pipe moves a tag one cycle early or late on its bus, so it shows at the first op through that resource. A pipe that reset fails to flush shows stale tags in the cycle right after the reset cycle. Illegal decoding shows up directly as a mismatch on ready and illegal_o in the offering cycle, or as a writeback that should not exist.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;

    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_V256 = 2'd1,
        OP_V512 = 2'd2,
        OP_RSVD = 2'd3
    } op_kind_e;

    // who holds the port 1 vector lane in the current cycle
    typedef enum logic [1:0] {
        L1_IDLE,   // nobody wants it
        L1_OWN,    // port 1 256-bit op uses it
        L1_LENT,   // borrowed by a fused port 0 op
        L1_CLASH   // both want it: port 1 loses
    } lane1_mode_e;

    localparam int VEC_LAT = 4;
    localparam int INT_LAT = 1;

endpackage

// File: rtl/vdisp_latpipe.sv
module vdisp_latpipe #(
    parameter int LAT = 4,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic [LAT-1:0] stg_vld;
    logic [DW-1:0]  stg_dat [LAT];

    genvar s;
    generate
        for (s = 0; s < LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stg_vld[s] <= 1'b0;
                    else     stg_vld[s] <= in_valid;
                    stg_dat[s] <= in_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stg_vld[s] <= 1'b0;
                    else     stg_vld[s] <= stg_vld[s-1];
                    stg_dat[s] <= stg_dat[s-1];
                end
            end
        end
    endgenerate

    assign out_valid = stg_vld[LAT-1];
    assign out_data  = stg_dat[LAT-1];
endmodule

// File: rtl/vdisp_arbiter.sv
module vdisp_arbiter
    import vdisp_pkg::*;
#(
    parameter bit HAS_P5 = 1'b1
) (
    input  logic       p0_valid,
    input  logic [1:0] p0_kind,
    input  logic       p1_valid,
    input  logic [1:0] p1_kind,
    input  logic       p5_valid,
    input  logic [1:0] p5_kind,
    output logic       ready0,
    output logic       ready1,
    output logic       ready5,
    output logic       illegal,
    output logic       go_alu0,
    output logic       go_vl0,
    output logic       go_fused,
    output logic       go_alu1,
    output logic       go_vl1,
    output logic       go_u5
);
    op_kind_e    k0, k1, k5;
    lane1_mode_e l1_mode;
    logic        legal0, legal1, legal5;
    logic        fused_req, lane1_req;

    assign k0 = op_kind_e'(p0_kind);
    assign k1 = op_kind_e'(p1_kind);
    assign k5 = op_kind_e'(p5_kind);

    assign legal0 = (k0 != OP_RSVD);
    assign legal1 = (k1 == OP_INT) || (k1 == OP_V256);
    assign legal5 = HAS_P5 && (k5 == OP_V512);

    assign fused_req = p0_valid && (k0 == OP_V512);
    assign lane1_req = (k1 == OP_V256);

    always_comb begin
        if (fused_req && lane1_req) l1_mode = L1_CLASH;
        else if (fused_req)         l1_mode = L1_LENT;
        else if (lane1_req)         l1_mode = L1_OWN;
        else                        l1_mode = L1_IDLE;
    end

    always_comb begin
        unique case (l1_mode)
            L1_IDLE:  ready1 = legal1;
            L1_OWN:   ready1 = legal1;
            L1_LENT:  ready1 = legal1;
            L1_CLASH: ready1 = 1'b0;
            default:  ready1 = 1'b0;
        endcase
    end

    assign ready0 = legal0;
    assign ready5 = legal5;

    assign illegal = (p0_valid && !legal0) || (p1_valid && !legal1) ||
                     (p5_valid && !legal5);

    assign go_alu0  = p0_valid && (k0 == OP_INT);
    assign go_vl0   = p0_valid && (k0 == OP_V256);
    assign go_fused = fused_req;
    assign go_alu1  = p1_valid && ready1 && (k1 == OP_INT);
    assign go_vl1   = p1_valid && ready1 && (k1 == OP_V256);
    assign go_u5    = p5_valid && legal5;
endmodule

// File: rtl/vdisp_top.sv
module vdisp_top
    import vdisp_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter bit HAS_P5 = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             p0_valid,
    input  logic [1:0]       p0_kind,
    input  logic [TAG_W-1:0] p0_tag,
    input  logic             p1_valid,
    input  logic [1:0]       p1_kind,
    input  logic [TAG_W-1:0] p1_tag,
    input  logic             p5_valid,
    input  logic [1:0]       p5_kind,
    input  logic [TAG_W-1:0] p5_tag,
    output logic             p0_ready,
    output logic             p1_ready,
    output logic             p5_ready,
    output logic             illegal_o,
    output logic             wb_alu0_valid,
    output logic [TAG_W-1:0] wb_alu0_tag,
    output logic             wb_alu1_valid,
    output logic [TAG_W-1:0] wb_alu1_tag,
    output logic             wb_vl0_valid,
    output logic [TAG_W-1:0] wb_vl0_tag,
    output logic             wb_vl0_wide,
    output logic             wb_vl1_valid,
    output logic [TAG_W-1:0] wb_vl1_tag,
    output logic             wb_u5_valid,
    output logic [TAG_W-1:0] wb_u5_tag
);
    localparam int WIDE_DW = TAG_W + 1;

    logic go_alu0, go_vl0, go_fused, go_alu1, go_vl1, go_u5;
    logic [WIDE_DW-1:0] vl0_out;

    vdisp_arbiter #(.HAS_P5(HAS_P5)) i_arb (
        .p0_valid (p0_valid),
        .p0_kind  (p0_kind),
        .p1_valid (p1_valid),
        .p1_kind  (p1_kind),
        .p5_valid (p5_valid),
        .p5_kind  (p5_kind),
        .ready0   (p0_ready),
        .ready1   (p1_ready),
        .ready5   (p5_ready),
        .illegal  (illegal_o),
        .go_alu0  (go_alu0),
        .go_vl0   (go_vl0),
        .go_fused (go_fused),
        .go_alu1  (go_alu1),
        .go_vl1   (go_vl1),
        .go_u5    (go_u5)
    );

    vdisp_latpipe #(.LAT(INT_LAT), .DW(TAG_W)) i_alu0 (
        .clk(clk), .rst(rst),
        .in_valid(go_alu0), .in_data(p0_tag),
        .out_valid(wb_alu0_valid), .out_data(wb_alu0_tag)
    );

    vdisp_latpipe #(.LAT(INT_LAT), .DW(TAG_W)) i_alu1 (
        .clk(clk), .rst(rst),
        .in_valid(go_alu1), .in_data(p1_tag),
        .out_valid(wb_alu1_valid), .out_data(wb_alu1_tag)
    );

    // port 0 lane carries both plain 256-bit and fused 512-bit ops
    vdisp_latpipe #(.LAT(VEC_LAT), .DW(WIDE_DW)) i_vl0 (
        .clk(clk), .rst(rst),
        .in_valid(go_vl0 || go_fused), .in_data({go_fused, p0_tag}),
        .out_valid(wb_vl0_valid), .out_data(vl0_out)
    );
    assign wb_vl0_wide = vl0_out[TAG_W];
    assign wb_vl0_tag  = vl0_out[TAG_W-1:0];

    vdisp_latpipe #(.LAT(VEC_LAT), .DW(TAG_W)) i_vl1 (
        .clk(clk), .rst(rst),
        .in_valid(go_vl1), .in_data(p1_tag),
        .out_valid(wb_vl1_valid), .out_data(wb_vl1_tag)
    );

    generate
        if (HAS_P5) begin : g_u5
            vdisp_latpipe #(.LAT(VEC_LAT), .DW(TAG_W)) i_u5 (
                .clk(clk), .rst(rst),
                .in_valid(go_u5), .in_data(p5_tag),
                .out_valid(wb_u5_valid), .out_data(wb_u5_tag)
            );
        end else begin : g_no_u5
            assign wb_u5_valid = 1'b0;
            assign wb_u5_tag   = '0;
        end
    endgenerate
endmodule

// File: rtl/vdisp_checker.sv
module vdisp_checker #(
    parameter int TAG_W  = 6,
    parameter bit HAS_P5 = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             p0_valid,
    input logic [1:0]       p0_kind,
    input logic [TAG_W-1:0] p0_tag,
    input logic             p1_valid,
    input logic [1:0]       p1_kind,
    input logic             p5_valid,
    input logic             p1_ready,
    input logic             p5_ready,
    input logic             illegal_o,
    input logic             wb_alu0_valid,
    input logic [TAG_W-1:0] wb_alu0_tag,
    input logic             wb_alu1_valid,
    input logic             wb_vl0_valid,
    input logic             wb_vl0_wide,
    input logic             wb_vl1_valid,
    input logic             wb_u5_valid
);
    AST_FUSED_STALLS_P1: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_kind == 2'd2 && p1_kind == 2'd1) |-> !p1_ready); // R3

    AST_INT_BESIDE_FUSED: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_kind == 2'd2 && p1_valid && p1_kind == 2'd0) |-> p1_ready); // R4

    AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_kind == 2'd0) |=> (wb_alu0_valid && wb_alu0_tag == $past(p0_tag))); // R5

    AST_LENT_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wb_vl0_valid && wb_vl0_wide) |-> !wb_vl1_valid); // R2

    AST_NO_UNIT_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (!HAS_P5 && p5_valid) |-> (illegal_o && !p5_ready && !wb_u5_valid)); // R7

    AST_P1_WIDE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (p1_valid && p1_kind == 2'd2) |-> (illegal_o && !p1_ready)); // R8

    AST_RESET_FLUSH: assert property (@(posedge clk)
        rst |=> !(wb_alu0_valid || wb_alu1_valid || wb_vl0_valid ||
                  wb_vl1_valid || wb_u5_valid)); // R9
endmodule

bind vdisp_top vdisp_checker #(.TAG_W(TAG_W), .HAS_P5(HAS_P5)) i_vdisp_checker (.*);

// File: tb/test_vdisp_top.sv
module test_vdisp_top;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          p0_valid = 0, p1_valid = 0, p5_valid = 0;
    logic [1:0]    p0_kind = 0, p1_kind = 0, p5_kind = 0;
    logic [TW-1:0] p0_tag = 0, p1_tag = 0, p5_tag = 0;

    logic p0_ready, p1_ready, p5_ready, illegal_o;
    logic wb_alu0_valid, wb_alu1_valid, wb_vl0_valid, wb_vl0_wide, wb_vl1_valid, wb_u5_valid;
    logic [TW-1:0] wb_alu0_tag, wb_alu1_tag, wb_vl0_tag, wb_vl1_tag, wb_u5_tag;

    logic n_p0_ready, n_p1_ready, n_p5_ready, n_illegal;
    logic n_a0v, n_a1v, n_v0v, n_v0w, n_v1v, n_u5v;
    logic [TW-1:0] n_a0t, n_a1t, n_v0t, n_v1t, n_u5t;

    vdisp_top #(.TAG_W(TW), .HAS_P5(1'b1)) i_vdisp_top (
        .clk(clk), .rst(rst),
        .p0_valid(p0_valid), .p0_kind(p0_kind), .p0_tag(p0_tag),
        .p1_valid(p1_valid), .p1_kind(p1_kind), .p1_tag(p1_tag),
        .p5_valid(p5_valid), .p5_kind(p5_kind), .p5_tag(p5_tag),
        .p0_ready(p0_ready), .p1_ready(p1_ready), .p5_ready(p5_ready),
        .illegal_o(illegal_o),
        .wb_alu0_valid(wb_alu0_valid), .wb_alu0_tag(wb_alu0_tag),
        .wb_alu1_valid(wb_alu1_valid), .wb_alu1_tag(wb_alu1_tag),
        .wb_vl0_valid(wb_vl0_valid), .wb_vl0_tag(wb_vl0_tag), .wb_vl0_wide(wb_vl0_wide),
        .wb_vl1_valid(wb_vl1_valid), .wb_vl1_tag(wb_vl1_tag),
        .wb_u5_valid(wb_u5_valid), .wb_u5_tag(wb_u5_tag)
    );

    vdisp_top #(.TAG_W(TW), .HAS_P5(1'b0)) i_vdisp_top_nop5 (
        .clk(clk), .rst(rst),
        .p0_valid(p0_valid), .p0_kind(p0_kind), .p0_tag(p0_tag),
        .p1_valid(p1_valid), .p1_kind(p1_kind), .p1_tag(p1_tag),
        .p5_valid(p5_valid), .p5_kind(p5_kind), .p5_tag(p5_tag),
        .p0_ready(n_p0_ready), .p1_ready(n_p1_ready), .p5_ready(n_p5_ready),
        .illegal_o(n_illegal),
        .wb_alu0_valid(n_a0v), .wb_alu0_tag(n_a0t),
        .wb_alu1_valid(n_a1v), .wb_alu1_tag(n_a1t),
        .wb_vl0_valid(n_v0v), .wb_vl0_tag(n_v0t), .wb_vl0_wide(n_v0w),
        .wb_vl1_valid(n_v1v), .wb_vl1_tag(n_v1t),
        .wb_u5_valid(n_u5v), .wb_u5_tag(n_u5t)
    );

    // bus ids: 0 alu0, 1 alu1, 2 lane0, 3 lane1, 4 unit5
    typedef struct {
        int            due;
        int            bus;
        logic [TW-1:0] tag;
        logic          wide;
    } wb_item_t;

    wb_item_t exp_q[$];
    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    logic [TW-1:0] tag_ctr = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] new_tag();
        tag_ctr = tag_ctr + 1;
        return tag_ctr;
    endfunction

    // monitor: pops expected writebacks that fall due in this cycle
    always @(negedge clk) begin
        if (!done) begin
            for (int b = 0; b < 5; b++) begin
                logic          av, aw;
                logic [TW-1:0] at;
                int            hit;
                string         rq;
                case (b)
                    0: begin av = wb_alu0_valid; at = wb_alu0_tag; aw = 1'b0; rq = "R5"; end
                    1: begin av = wb_alu1_valid; at = wb_alu1_tag; aw = 1'b0; rq = "R4"; end
                    2: begin av = wb_vl0_valid;  at = wb_vl0_tag;  aw = wb_vl0_wide; rq = "R2"; end
                    3: begin av = wb_vl1_valid;  at = wb_vl1_tag;  aw = 1'b0; rq = "R1"; end
                    default: begin av = wb_u5_valid; at = wb_u5_tag; aw = 1'b0; rq = "R7"; end
                endcase
                hit = -1;
                for (int i = 0; i < exp_q.size(); i++)
                    if (exp_q[i].bus == b && exp_q[i].due == cyc) hit = i;
                if (hit >= 0) begin
                    chk(av === 1'b1, rq, $sformatf("bus%0d valid", b), int'(av), 1);
                    chk(at === exp_q[hit].tag, rq, $sformatf("bus%0d tag", b), int'(at), int'(exp_q[hit].tag));
                    if (b == 2)
                        chk(aw === exp_q[hit].wide, "R2", "lane0 wide", int'(aw), int'(exp_q[hit].wide));
                    exp_q.delete(hit);
                end else begin
                    chk(av === 1'b0, rq, $sformatf("bus%0d spurious valid", b), int'(av), 0);
                end
            end
            chk(n_u5v === 1'b0, "R7", "no-unit build unit5 valid", int'(n_u5v), 0);
        end
    end

    // one dispatch cycle; caller is at a falling edge
    task automatic drive(input string req,
                         input bit v0, input logic [1:0] k0, input logic [TW-1:0] t0,
                         input bit v1, input logic [1:0] k1, input logic [TW-1:0] t1,
                         input bit v5, input logic [1:0] k5, input logic [TW-1:0] t5,
                         output bit iss1);
        bit l0, l1, l5, r1, il, iln;
        p0_valid = v0; p0_kind = k0; p0_tag = t0;
        p1_valid = v1; p1_kind = k1; p1_tag = t1;
        p5_valid = v5; p5_kind = k5; p5_tag = t5;
        #1;
        l0 = (k0 != 2'd3);
        l1 = (k1 == 2'd0) || (k1 == 2'd1);
        l5 = (k5 == 2'd2);
        r1 = l1 && !(v0 && k0 == 2'd2 && k1 == 2'd1);
        il  = (v0 && !l0) || (v1 && !l1) || (v5 && !l5);
        iln = (v0 && !l0) || (v1 && !l1) || v5;
        chk(p0_ready === l0, (k0 == 2'd3) ? "R8" : req, "p0_ready", int'(p0_ready), int'(l0));
        chk(p1_ready === r1, (l1 && !r1) ? "R3" : ((k1 == 2'd1 || k1 == 2'd0) ? req : "R8"),
            "p1_ready", int'(p1_ready), int'(r1));
        chk(p5_ready === l5, (k5 == 2'd2) ? "R7" : "R8", "p5_ready", int'(p5_ready), int'(l5));
        chk(illegal_o === il, "R8", "illegal_o", int'(illegal_o), int'(il));
        chk(n_p5_ready === 1'b0, "R7", "no-unit p5_ready", int'(n_p5_ready), 0);
        chk(n_illegal === iln, "R8", "no-unit illegal_o", int'(n_illegal), int'(iln));
        if (v0 && k0 == 2'd0) exp_q.push_back('{cyc + 1, 0, t0, 1'b0});
        if (v0 && k0 == 2'd1) exp_q.push_back('{cyc + 4, 2, t0, 1'b0});
        if (v0 && k0 == 2'd2) exp_q.push_back('{cyc + 4, 2, t0, 1'b1});
        if (v1 && r1 && k1 == 2'd0) exp_q.push_back('{cyc + 1, 1, t1, 1'b0});
        if (v1 && r1 && k1 == 2'd1) exp_q.push_back('{cyc + 4, 3, t1, 1'b0});
        if (v5 && l5) exp_q.push_back('{cyc + 4, 4, t5, 1'b0});
        iss1 = v1 && r1;
    endtask

    task automatic idle(input int n);
        bit d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive("R1", 0, 2'd0, '0, 0, 2'd0, '0, 0, 2'd2, '0, d);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        p0_valid = 0; p1_valid = 0; p5_valid = 0;
        rst = 1'b1;
        for (int i = exp_q.size() - 1; i >= 0; i--)
            if (exp_q[i].due > cyc) exp_q.delete(i);
        @(negedge clk);
        chk(!(wb_alu0_valid || wb_alu1_valid || wb_vl0_valid || wb_vl1_valid || wb_u5_valid),
            "R9", "writebacks after reset", 1, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk(!(wb_alu0_valid || wb_alu1_valid || wb_vl0_valid || wb_vl1_valid || wb_u5_valid),
            "R9", "outputs quiet after reset", 1, 0);
        chk(illegal_o === 1'b0, "R9", "illegal after reset", int'(illegal_o), 0);

        // R1 simple mapping
        @(negedge clk); drive("R1", 1, 2'd0, new_tag(), 1, 2'd0, new_tag(), 0, 2'd2, '0, d);
        @(negedge clk); drive("R1", 1, 2'd1, new_tag(), 1, 2'd1, new_tag(), 0, 2'd2, '0, d);
        idle(5);
        // R2 fused alone
        @(negedge clk); drive("R2", 1, 2'd2, new_tag(), 0, 2'd0, '0, 0, 2'd2, '0, d);
        idle(5);
        // R3 clash: stalled, then retried
        begin
            logic [TW-1:0] held;
            held = new_tag();
            @(negedge clk); drive("R3", 1, 2'd2, new_tag(), 1, 2'd1, held, 0, 2'd2, '0, d);
            chk(d == 1'b0, "R3", "port1 vector issued during fuse", int'(d), 0);
            @(negedge clk); drive("R3", 0, 2'd0, '0, 1, 2'd1, held, 0, 2'd2, '0, d);
            chk(d == 1'b1, "R3", "port1 vector retry issued", int'(d), 1);
        end
        idle(5);
        // R4 scalar beside fused
        @(negedge clk); drive("R4", 1, 2'd2, new_tag(), 1, 2'd0, new_tag(), 1, 2'd2, new_tag(), d);
        idle(5);
        // R6 back to back on every resource
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            drive("R6", 1, (i < 3) ? 2'd1 : 2'd0, new_tag(), 1, (i % 2 == 0) ? 2'd1 : 2'd0,
                  new_tag(), 1, 2'd2, new_tag(), d);
        end
        idle(5);
        // R7 / R8 illegal offers
        @(negedge clk); drive("R8", 1, 2'd3, new_tag(), 1, 2'd2, new_tag(), 1, 2'd0, new_tag(), d);
        @(negedge clk); drive("R8", 0, 2'd0, '0, 1, 2'd3, new_tag(), 1, 2'd1, new_tag(), d);
        @(negedge clk); drive("R7", 0, 2'd0, '0, 0, 2'd0, '0, 1, 2'd2, new_tag(), d);
        idle(5);
        // R9 reset with work in flight
        @(negedge clk); drive("R9", 1, 2'd2, new_tag(), 1, 2'd0, new_tag(), 1, 2'd2, new_tag(), d);
        @(negedge clk); drive("R9", 1, 2'd1, new_tag(), 1, 2'd1, new_tag(), 0, 2'd2, '0, d);
        pulse_reset();
        idle(5);

        // randomized mix with held port 1 ops
        begin
            bit            hold1 = 0;
            logic [1:0]    hk1 = 0;
            logic [TW-1:0] ht1 = 0;
            for (int c = 0; c < 3000; c++) begin
                bit v0, v1, v5, iss;
                logic [1:0] k0, k1, k5;
                int r;
                v0 = ($urandom % 4) != 0;
                r = $urandom % 20; k0 = (r < 8) ? 2'd0 : (r < 13) ? 2'd1 : (r < 19) ? 2'd2 : 2'd3;
                if (hold1) begin
                    v1 = 1; k1 = hk1;
                end else begin
                    v1 = ($urandom % 4) != 0;
                    r = $urandom % 20; k1 = (r < 9) ? 2'd0 : (r < 18) ? 2'd1 : (r < 19) ? 2'd2 : 2'd3;
                    ht1 = new_tag();
                end
                v5 = ($urandom % 3) == 0;
                r = $urandom % 10; k5 = (r < 9) ? 2'd2 : 2'd1;
                @(negedge clk);
                drive("R6", v0, k0, new_tag(), v1, k1, ht1, v5, k5, new_tag(), iss);
                hold1 = v1 && !iss && (k1 == 2'd1);
                hk1 = k1;
                if (c == 1500) begin
                    pulse_reset();
                    hold1 = 0;
                end
            end
        end
        idle(6);
        done = 1;
        chk(exp_q.size() == 0, "R5", "writebacks left outstanding", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule